// File: doc/BRIEF.md
# Quadrature Encoder Decoder

This block turns the two phase signals and the index pulse of an incremental
rotary or linear encoder into a 16-bit position count. All three encoder
pins are first brought into the system clock domain and then cleaned by
digital glitch filters. The filters sample on a filter clock that is the
system clock divided by a selectable power of two. The filtered phases are
decoded at either twice or four times the line resolution. Each counted edge
moves the position counter up or down and records the direction of travel.

The counter wraps against a programmed maximum. Moving up from the maximum
gives zero, moving down from zero gives the maximum, and each wrap raises a
one-cycle interrupt pulse. A rising index edge can clear the count when that
option is on. A phase pattern in which both phases change at once cannot be
decoded. It is dropped and latched in a sticky error flag. A separate mode
ignores the encoder and runs the counter as a plain timer that advances once
per filter-clock tick.

Top module: `qdec_top`

## Requirements
- R1: After reset, `pos_count` is 0, `dir_up` is 1, `irq` is 0 and `phase_err` is 0.
- R2: With `mode` = 2'b11 (x4), every single-phase edge of the filtered inputs counts. The sequence (A,B) 00→10→11→01→00, in which A leads B, counts up by one per edge, and the reverse sequence counts down by one per edge.
- R3: With `mode` = 2'b10 (x2), only edges of phase A count, using the same direction rule. Edges of phase B leave `pos_count` unchanged.
- R4: `dir_up` takes the direction of the most recent counted edge: 1 for forward (A leads B) and 0 for reverse.
- R5: Each input is synchronised and filtered. A new level is accepted only after three consecutive equal samples on the filter clock, so a pulse shorter than two filter-clock periods has no effect. The filter clock period is 2^`filt_sel` system cycles, and a `filt_sel` value above 8 acts as 8.
- R6: Counting up when `pos_count` is at or above `max_count` loads 0 and raises `irq` for exactly one cycle, in the same cycle as the new count.
- R7: Counting down when `pos_count` is 0 loads `max_count` and raises `irq` for one cycle.
- R8: In x2 or x4 mode, a change of both filtered phases in the same sample is not counted, and it sets `phase_err`. Once set, `phase_err` stays set until reset.
- R9: In x2 or x4 mode, with `idx_clr_en` = 1, a rising edge of the filtered index clears `pos_count` to 0. With `idx_clr_en` = 0, the index has no effect.
- R10: With `mode` = 2'b01 (timer), `pos_count` increases by one on each filter-clock tick and wraps as in R6. The encoder phases are ignored.
- R11: With `mode` = 2'b00 (off), `pos_count` holds its value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index pulse, asynchronous |
| mode | input | 2 | 00 off, 01 timer, 10 x2 decode, 11 x4 decode |
| filt_sel | input | 4 | Filter clock divide exponent (period 2^n cycles, saturates at 8) |
| idx_clr_en | input | 1 | Clear the count on a rising index edge |
| max_count | input | 16 | Wrap value of the counter |
| pos_count | output | 16 | Position or timer count |
| dir_up | output | 1 | Direction of the last counted edge, 1 = forward |
| irq | output | 1 | One-cycle pulse on rollover or underflow |
| phase_err | output | 1 | Sticky flag for an undecodable phase transition |

## Verification
The hardest case to bring about from the ports is a change of both phases in
the same filter sample. The two pins must be flipped in the same cycle, so
that the matching synchroniser and filter pipelines deliver both changes
together. The bench therefore drives both pins from one task call. Filter
rejection at the longest divide is also hard to reach. It needs a glitch that
is just under two filter-clock periods, so the bench uses a 500-cycle pulse
with `filt_sel` set above 8, and then a slow genuine step to show that the
filter still accepts real edges. Wrap-around in both directions is reached by
a long random walk against a small maximum.

// File: rtl/qdec_pkg.sv
// Shared types for the quadrature encoder decoder.
package qdec_pkg;

    // Operating mode selected at the mode port.
    typedef enum logic [1:0] {
        QM_OFF   = 2'b00,
        QM_TIMER = 2'b01,
        QM_X2    = 2'b10,
        QM_X4    = 2'b11
    } qmode_e;

    // One decoded movement event for the counter.
    typedef struct packed {
        logic step;   // a countable edge occurred this cycle
        logic up;     // its direction, 1 = forward
    } qstep_t;

endpackage

// File: rtl/qdec_prescaler.sv
// Filter-clock enable generator.
// Produces a one-cycle tick every 2^sel system cycles; sel above MAX_SHIFT
// saturates. Assumes MAX_SHIFT fits in SEL_W bits.
module qdec_prescaler #(
    parameter int SEL_W     = 4,
    parameter int MAX_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    logic [CW-1:0]    div_q;
    logic [SEL_W-1:0] sel_sat;
    logic [CW:0]      one_hot;
    logic [CW:0]      mask_full;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + CW'(1);
    end

    // Clamp the exponent and build the low-bit mask.
    always_comb begin
        sel_sat   = (sel > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel;
        one_hot   = (CW+1)'(1) << sel_sat;
        mask_full = one_hot - (CW+1)'(1);
    end

    // Tick when all masked low bits are set.
    assign tick = ((div_q & mask_full[CW-1:0]) == mask_full[CW-1:0]);

endmodule

// File: rtl/qdec_filter.sv
// Input synchroniser and glitch filter for one encoder pin.
// The pin is assumed asynchronous and low during reset. The output takes a
// new level only after VOTE consecutive equal samples taken on tick.
// Assumes SYNC_STAGES >= 2 and VOTE >= 2.
module qdec_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic dout
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE-2:0]        hist_q;
    logic                   s;
    logic                   agree;

    // Bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign s     = sync_q[SYNC_STAGES-1];
    assign agree = (hist_q == {(VOTE-1){s}});

    // Sample history shifted on each filter tick.
    generate
        if (VOTE == 2) begin : g_hist1
            always_ff @(posedge clk) begin
                if (!rst_n)    hist_q <= '0;
                else if (tick) hist_q <= s;
            end
        end else begin : g_histn
            always_ff @(posedge clk) begin
                if (!rst_n)    hist_q <= '0;
                else if (tick) hist_q <= {hist_q[VOTE-3:0], s};
            end
        end
    endgenerate

    // Accept the level once enough equal samples agree.
    always_ff @(posedge clk) begin
        if (!rst_n)             dout <= 1'b0;
        else if (tick && agree) dout <= s;
    end

endmodule

// File: rtl/qdec_decoder.sv
// Quadrature edge decoder.
// Compares filtered phases against their previous values, then reports
// countable steps (x2: phase A edges only, x4: all single-phase edges), the
// last direction, a sticky error for simultaneous phase changes, and index
// rising edges. The previous values are tracked in every mode, so a mode
// switch produces no false edge.
module qdec_decoder
    import qdec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  qmode_e mode,
    input  logic   fa,
    input  logic   fb,
    input  logic   fidx,
    output qstep_t step,
    output logic   dir_up,
    output logic   err,
    output logic   idx_rise
);
    logic prev_a, prev_b, prev_idx;
    logic ch_a, ch_b, quad, single, both, counted, up;

    // Remember the last filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a   <= 1'b0;
            prev_b   <= 1'b0;
            prev_idx <= 1'b0;
        end else begin
            prev_a   <= fa;
            prev_b   <= fb;
            prev_idx <= fidx;
        end
    end

    // Classify the transition seen this cycle.
    always_comb begin
        ch_a    = fa ^ prev_a;
        ch_b    = fb ^ prev_b;
        quad    = (mode == QM_X2) || (mode == QM_X4);
        single  = ch_a ^ ch_b;
        both    = ch_a & ch_b;
        counted = quad && single && ((mode == QM_X4) || ch_a);
        // Forward: an A edge leaves A != B, a B edge leaves B == A.
        up      = ch_a ? (fa ^ fb) : ~(fa ^ fb);
    end

    assign step.step = counted;
    assign step.up   = up;
    assign idx_rise  = fidx & ~prev_idx;

    // Direction of the most recent counted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_up <= 1'b1;
        else if (counted) dir_up <= up;
    end

    // Sticky flag for an undecodable transition.
    always_ff @(posedge clk) begin
        if (!rst_n)           err <= 1'b0;
        else if (quad && both) err <= 1'b1;
    end

endmodule

// File: rtl/qdec_counter.sv
// Wrapping position / timer counter.
// Counts up or down on decoder steps, or up on timer ticks, and wraps
// against max_val with a one-cycle irq. An index clear has the highest
// priority. Assumes at most one event per cycle from the selected source.
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  qmode_e           mode,
    input  logic             tick,
    input  qstep_t           step,
    input  logic             idx_clr,
    input  logic [CNT_W-1:0] max_val,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic quad, inc, dec;

    // Select the counting source for the current mode.
    always_comb begin
        quad = (mode == QM_X2) || (mode == QM_X4);
        inc  = (mode == QM_TIMER) ? tick : (quad && step.step && step.up);
        dec  = quad && step.step && !step.up;
    end

    // Update the count and generate the wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (idx_clr) begin
                cnt <= '0;
            end else if (inc) begin
                if (cnt >= max_val) begin
                    cnt <= '0;
                    irq <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end else if (dec) begin
                if (cnt == '0) begin
                    cnt <= max_val;
                    irq <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/qdec_top.sv
// Quadrature encoder decoder top level.
// Filters the three encoder pins, decodes phase edges in x2 or x4 mode and
// drives a wrapping counter, or runs that counter as a timer. The encoder
// pins are asynchronous and low while reset is held.
module qdec_top
    import qdec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SEL_W       = 4,
    parameter int MAX_SHIFT   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int VOTE        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic [1:0]       mode,
    input  logic [SEL_W-1:0] filt_sel,
    input  logic             idx_clr_en,
    input  logic [CNT_W-1:0] max_count,
    output logic [CNT_W-1:0] pos_count,
    output logic             dir_up,
    output logic             irq,
    output logic             phase_err
);
    localparam int NPINS = 3;

    qmode_e          mode_e;
    logic            tick;
    logic [NPINS-1:0] raw_pins;
    logic [NPINS-1:0] flt_pins;
    qstep_t          step;
    logic            idx_rise;
    logic            idx_clr;

    assign mode_e   = qmode_e'(mode);
    assign raw_pins = {enc_idx, enc_b, enc_a};

    qdec_prescaler #(
        .SEL_W     (SEL_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (filt_sel),
        .tick  (tick)
    );

    // One filter per encoder pin.
    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_flt
            qdec_filter #(
                .SYNC_STAGES (SYNC_STAGES),
                .VOTE        (VOTE)
            ) u_flt (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .din   (raw_pins[i]),
                .dout  (flt_pins[i])
            );
        end
    endgenerate

    qdec_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .fa       (flt_pins[0]),
        .fb       (flt_pins[1]),
        .fidx     (flt_pins[2]),
        .step     (step),
        .dir_up   (dir_up),
        .err      (phase_err),
        .idx_rise (idx_rise)
    );

    assign idx_clr = idx_clr_en && idx_rise &&
                     ((mode_e == QM_X2) || (mode_e == QM_X4));

    qdec_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_e),
        .tick    (tick),
        .step    (step),
        .idx_clr (idx_clr),
        .max_val (max_count),
        .cnt     (pos_count),
        .irq     (irq)
    );

endmodule

// File: rtl/qdec_checker.sv
// Port-level properties of qdec_top, attached with bind.
module qdec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] max_count,
    input logic [CNT_W-1:0] pos_count,
    input logic             irq,
    input logic             phase_err
);
    // R6, R7: a wrap pulse comes with zero or the previous maximum.
    a_r6_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pos_count == '0 || pos_count == $past(max_count)));

    // R8: the error flag is sticky.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |=> phase_err);

    // R11: the off mode freezes the count.
    a_r11_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> $stable(pos_count));

    // R10: the timer only ever steps up by one or wraps.
    a_r10_timer_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (irq || $stable(pos_count) ||
                             pos_count == $past(pos_count) + CNT_W'(1)));

    // R2: outside a wrap, the count moves by one or is cleared.
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !$stable(pos_count)) |->
            (pos_count == $past(pos_count) + CNT_W'(1) ||
             pos_count == $past(pos_count) - CNT_W'(1) ||
             pos_count == '0));
endmodule

bind qdec_top qdec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .max_count (max_count),
    .pos_count (pos_count),
    .irq       (irq),
    .phase_err (phase_err)
);

// File: tb/tb_qdec_top.sv
module tb_qdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [3:0]  filt_sel = 4'd0;
    logic        idx_clr_en = 1'b0;
    logic [15:0] max_count = 16'd1000;
    logic [15:0] pos_count;
    logic        dir_up, irq, phase_err;

    int n_tests = 0, n_fail = 0;
    int irq_seen = 0;
    int exp_cnt = 0, exp_irq = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    qdec_top dut (.*);

    // Count interrupt pulses between edges.
    always @(negedge clk) if (rst_n && irq) irq_seen++;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Next phase state in the forward (A leads B) order 00,10,11,01.
    function automatic logic [1:0] fwd_state(input logic [1:0] ab);
        case (ab)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] rev_state(input logic [1:0] ab);
        case (ab)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // Model one counted edge against the maximum.
    task automatic model_count(input bit up);
        if (up) begin
            if (exp_cnt >= int'(max_count)) begin exp_cnt = 0; exp_irq++; end
            else exp_cnt++;
        end else begin
            if (exp_cnt == 0) begin exp_cnt = int'(max_count); exp_irq++; end
            else exp_cnt--;
        end
    endtask

    // cm: 0 none, 1 x2, 2 x4
    task automatic move(input bit up, input int cm, input int hold);
        logic [1:0] cur, nxt;
        cur = {enc_a, enc_b};
        nxt = up ? fwd_state(cur) : rev_state(cur);
        if (cm == 2 || (cm == 1 && nxt[1] != cur[1])) model_count(up);
        @(negedge clk);
        {enc_a, enc_b} = nxt;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        int prev, cur, changes, bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 count after reset", pos_count, 0);
        chk("R1 dir after reset", dir_up, 1);
        chk("R1 irq after reset", irq, 0);
        chk("R1 err after reset", phase_err, 0);

        // Directed x4 moves and both wraps.
        mode = 2'b11;
        for (int i = 0; i < 4; i++) move(1'b1, 2, 8);
        chk("R2 x4 forward count", pos_count, 4);
        chk("R4 dir forward", dir_up, 1);
        for (int i = 0; i < 4; i++) move(1'b0, 2, 8);
        chk("R2 x4 reverse count", pos_count, 0);
        chk("R4 dir reverse", dir_up, 0);
        move(1'b0, 2, 8);
        chk("R7 underflow loads max", pos_count, 1000);
        chk("R7 underflow irq", irq_seen, 1);
        move(1'b1, 2, 8);
        chk("R6 rollover to zero", pos_count, 0);
        chk("R6 rollover irq", irq_seen, 2);

        // Random walk against a small maximum.
        void'($urandom(32'd12345));
        max_count = 16'd37;
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            move(1'($urandom_range(0, 1)), 2, 8);
            if (int'(pos_count) != exp_cnt) bad++;
        end
        chk("R2 R6 R7 x4 random walk mismatches", bad, 0);
        chk("R6 R7 random walk irq total", irq_seen, exp_irq);

        // x2 decoding.
        mode = 2'b10;
        prev = exp_cnt;
        for (int i = 0; i < 4; i++) move(1'b1, 1, 8);
        chk("R3 x2 four edges", pos_count, (prev + 2 > 37) ? exp_cnt : prev + 2);
        bad = 0;
        for (int i = 0; i < 150; i++) begin
            move(1'($urandom_range(0, 1)), 1, 8);
            if (int'(pos_count) != exp_cnt) bad++;
        end
        chk("R3 x2 random walk mismatches", bad, 0);
        chk("R3 x2 irq total", irq_seen, exp_irq);

        // Glitch rejection.
        mode = 2'b11;
        prev = int'(pos_count);
        enc_a = ~enc_a; repeat (2) @(negedge clk); enc_a = ~enc_a;
        repeat (12) @(negedge clk);
        chk("R5 2-cycle glitch ignored", pos_count, prev);
        filt_sel = 4'd3;
        repeat (20) @(negedge clk);
        enc_b = ~enc_b; repeat (12) @(negedge clk); enc_b = ~enc_b;
        repeat (60) @(negedge clk);
        chk("R5 12-cycle glitch at div8 ignored", pos_count, prev);
        move(1'b1, 2, 48);
        chk("R5 slow step at div8 counted", pos_count, exp_cnt);
        filt_sel = 4'd12;
        prev = int'(pos_count);
        enc_a = ~enc_a; repeat (500) @(negedge clk); enc_a = ~enc_a;
        repeat (800) @(negedge clk);
        chk("R5 500-cycle glitch at saturated div ignored", pos_count, prev);
        move(1'b0, 2, 1300);
        chk("R5 step at saturated div counted", pos_count, exp_cnt);
        filt_sel = 4'd0;
        repeat (20) @(negedge clk);

        // Simultaneous phase change.
        chk("R8 no error yet", phase_err, 0);
        prev = int'(pos_count);
        enc_a = ~enc_a; enc_b = ~enc_b;
        repeat (10) @(negedge clk);
        chk("R8 double change not counted", pos_count, prev);
        chk("R8 error set", phase_err, 1);
        move(1'b1, 2, 8);
        chk("R8 error sticky", phase_err, 1);
        chk("R8 counting resumes", pos_count, exp_cnt);

        // Index clear.
        move(1'b1, 2, 8); move(1'b1, 2, 8);
        idx_clr_en = 1'b0;
        enc_idx = 1'b1; repeat (10) @(negedge clk); enc_idx = 1'b0;
        repeat (10) @(negedge clk);
        chk("R9 index ignored when disabled", pos_count, exp_cnt);
        idx_clr_en = 1'b1;
        enc_idx = 1'b1; repeat (10) @(negedge clk); enc_idx = 1'b0;
        repeat (10) @(negedge clk);
        exp_cnt = 0;
        chk("R9 index clears count", pos_count, 0);
        idx_clr_en = 1'b0;

        // Off mode holds.
        move(1'b1, 2, 8);
        mode = 2'b00;
        prev = int'(pos_count);
        for (int i = 0; i < 6; i++) move(1'b1, 0, 8);
        chk("R11 off mode holds", pos_count, prev);

        // Timer mode, every cycle.
        max_count = 16'd50;
        mode = 2'b01;
        @(negedge clk);
        prev = int'(pos_count);
        bad = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            cur = int'(pos_count);
            if (i % 7 == 0) enc_a = ~enc_a;
            if (cur != ((prev >= 50) ? 0 : prev + 1)) bad++;
            prev = cur;
        end
        chk("R10 timer per-cycle mismatches", bad, 0);
        // Timer at divide 4.
        filt_sel = 4'd2;
        repeat (4) @(negedge clk);
        prev = int'(pos_count);
        changes = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (int'(pos_count) != prev) changes++;
            prev = int'(pos_count);
        end
        chk("R10 timer ticks in 40 cycles at div4", changes, 10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all) actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule